// File: doc/BRIEF.md
# Program Memory Byte Transfer Pointer

This block moves one byte at a time between a byte-addressed program memory and an 8-bit holding latch. A 21-bit pointer names the memory byte. Each byte has its own address, so a 16-bit program word keeps its low byte at the even address and its high byte at the next odd address. A read command copies the byte at the pointer into the latch. A write command sends the latch byte to the pointer's address. Each command carries a 2-bit addressing mode. The mode says whether the pointer stays put, steps after the access, or steps before it.

Commands arrive on a valid/ready port. `cmd_ready` is high only when the block is idle and no direct load is being presented. A command stays pending on the producer's side until the cycle in which both `cmd_valid` and `cmd_ready` are high. While a transfer runs, `busy` is high and `cmd_ready` is low, which holds off the producer. The memory side is a plain strobe port: a level read request that waits for a read-valid response, and a write strobe that lasts one cycle. A separate load input writes the pointer and the latch directly while the block is idle.

Top module: `tbl_ptr_xfer`

## Requirements
- R1: After reset the pointer and the latch are zero, and `busy`, `done`, `mem_rd` and `mem_wr` are low.
- R2: A command is taken on a rising edge where `cmd_valid` and `cmd_ready` are both high. `cmd_ready` equals "idle and `ld_en` low". `busy` is high from the cycle after acceptance until the completion edge.
- R3: For a read, `mem_rd` stays high with `mem_addr` equal to the access address, from the cycle after acceptance through the cycle in which `mem_rvalid` is sampled high. At that edge the latch takes `mem_rdata`. `mem_rvalid` is ignored at all other times.
- R4: For a write, `mem_wr` is high for exactly one cycle, the cycle after acceptance, with `mem_addr` at the access address and `mem_wdata` equal to the latch. The transfer completes at the end of that cycle.
- R5: Mode 0 (plain) leaves the pointer unchanged by the transfer.
- R6: Mode 1 (post-increment) accesses the current pointer, then adds 1 to it at the completion edge.
- R7: Mode 2 (post-decrement) accesses the current pointer, then subtracts 1 from it at the completion edge.
- R8: Mode 3 (pre-increment) adds 1 to the pointer at the acceptance edge. The access uses the new value, and the pointer keeps that value afterwards.
- R9: All pointer arithmetic wraps modulo 2^21: 0x1FFFFF + 1 gives 0, and 0 - 1 gives 0x1FFFFF.
- R10: `ld_en` high while idle writes `ld_ptr` into the pointer and `ld_latch` into the latch at the next edge, and takes priority over a command. While busy, `ld_en` has no effect.
- R11: `done` is a one-cycle pulse in the cycle after each completion edge. `busy` is low in that cycle.
- R12: `mem_rd` and `mem_wr` are never high together, and neither is high while the block is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command presented |
| cmd_ready | output | 1 | Command can be taken this cycle |
| cmd_write | input | 1 | 1 = write latch to memory, 0 = read memory into latch |
| cmd_mode | input | 2 | Addressing mode: 0 plain, 1 post-inc, 2 post-dec, 3 pre-inc |
| ld_en | input | 1 | Direct load of pointer and latch (idle only) |
| ld_ptr | input | 21 | Pointer value for direct load |
| ld_latch | input | 8 | Latch value for direct load |
| mem_addr | output | 21 | Memory byte address |
| mem_rd | output | 1 | Read request, held until read-valid |
| mem_wr | output | 1 | One-cycle write strobe |
| mem_wdata | output | 8 | Write data |
| mem_rdata | input | 8 | Read data |
| mem_rvalid | input | 1 | Read data valid |
| ptr | output | 21 | Current pointer |
| latch | output | 8 | Current latch byte |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | Transfer-complete pulse |

## Verification
An accepted command raises `busy` and the memory strobe one cycle after the acceptance edge. A pre-increment shows its new pointer in that same cycle. A write completes one edge later. A read completes at the first edge at which `mem_rvalid` is high. The post-step of the pointer, the captured latch byte and the `done` pulse all appear in the cycle after completion. The bench's reference model advances on each rising edge using the same inputs the design sees. All outputs are compared at the falling edge, after the registers have settled and before new stimulus is driven, so every result is checked in exactly the cycle it is due. The read-valid delay varies from zero to three cycles, and noise on `mem_rvalid` outside reads checks that it is ignored.

// File: rtl/tpx_pkg.sv
package tpx_pkg;

  // Addressing mode carried with each command; the encoding is visible at the port.
  typedef enum logic [1:0] {
    AM_PLAIN    = 2'd0,
    AM_POST_INC = 2'd1,
    AM_POST_DEC = 2'd2,
    AM_PRE_INC  = 2'd3
  } amode_e;

  // Update applied to the pointer register at a clock edge.
  typedef enum logic [1:0] {
    PT_HOLD = 2'd0,
    PT_LOAD = 2'd1,
    PT_INC  = 2'd2,
    PT_DEC  = 2'd3
  } ptr_op_e;

  // Sequencer state.
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_READ  = 2'd1,
    ST_WRITE = 2'd2
  } xfer_st_e;

  // Pointer step that follows the access for a given mode.
  function automatic ptr_op_e post_step(amode_e m);
    ptr_op_e r;
    case (m)
      AM_POST_INC: r = PT_INC;
      AM_POST_DEC: r = PT_DEC;
      default:     r = PT_HOLD;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/tpx_ptr_reg.sv
module tpx_ptr_reg
  import tpx_pkg::*;
#(
  parameter int ADDR_W = 21
) (
  input  logic              clk,
  input  logic              rst_n,
  input  ptr_op_e           op,
  input  logic [ADDR_W-1:0] load_val,
  output logic [ADDR_W-1:0] ptr_q
);

  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(1);

  logic [ADDR_W-1:0] ptr_d;

  // Addition and subtraction at ADDR_W bits wrap modulo 2^ADDR_W.
  always_comb begin
    case (op)
      PT_LOAD: ptr_d = load_val;
      PT_INC:  ptr_d = ptr_q + STEP;
      PT_DEC:  ptr_d = ptr_q - STEP;
      default: ptr_d = ptr_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ptr_q <= '0;
    else        ptr_q <= ptr_d;
  end

endmodule

// File: rtl/tpx_latch_reg.sv
module tpx_latch_reg #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              sel_mem,
  input  logic [DATA_W-1:0] ext_val,
  input  logic [DATA_W-1:0] mem_val,
  output logic [DATA_W-1:0] q
);

  logic [DATA_W-1:0] d;

  assign d = sel_mem ? mem_val : ext_val;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     q <= '0;
    else if (wr_en) q <= d;
  end

endmodule

// File: rtl/tpx_ctrl.sv
module tpx_ctrl
  import tpx_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    cmd_valid,
  input  logic    cmd_write,
  input  amode_e  cmd_mode,
  input  logic    ld_en,
  input  logic    mem_rvalid,
  output logic    cmd_ready,
  output logic    busy,
  output logic    done,
  output logic    mem_rd,
  output logic    mem_wr,
  output ptr_op_e ptr_op,
  output logic    latch_en,
  output logic    latch_sel_mem
);

  xfer_st_e st_q, st_d;
  amode_e   mode_q;
  logic     done_q, finish;

  always_comb begin
    st_d          = st_q;
    ptr_op        = PT_HOLD;
    latch_en      = 1'b0;
    latch_sel_mem = 1'b0;
    finish        = 1'b0;
    case (st_q)
      ST_IDLE: begin
        if (ld_en) begin
          ptr_op   = PT_LOAD;
          latch_en = 1'b1;
        end else if (cmd_valid) begin
          st_d = cmd_write ? ST_WRITE : ST_READ;
          if (cmd_mode == AM_PRE_INC) ptr_op = PT_INC;
        end
      end
      ST_READ: begin
        if (mem_rvalid) begin
          latch_en      = 1'b1;
          latch_sel_mem = 1'b1;
          ptr_op        = post_step(mode_q);
          st_d          = ST_IDLE;
          finish        = 1'b1;
        end
      end
      ST_WRITE: begin
        ptr_op = post_step(mode_q);
        st_d   = ST_IDLE;
        finish = 1'b1;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      mode_q <= AM_PLAIN;
      done_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      done_q <= finish;
      if (st_q == ST_IDLE && !ld_en && cmd_valid) mode_q <= cmd_mode;
    end
  end

  assign cmd_ready = (st_q == ST_IDLE) && !ld_en;
  assign busy      = (st_q != ST_IDLE);
  assign done      = done_q;
  assign mem_rd    = (st_q == ST_READ);
  assign mem_wr    = (st_q == ST_WRITE);

endmodule

// File: rtl/tbl_ptr_xfer.sv
module tbl_ptr_xfer
  import tpx_pkg::*;
#(
  parameter int ADDR_W = 21,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic              cmd_write,
  input  logic [1:0]        cmd_mode,
  input  logic              ld_en,
  input  logic [ADDR_W-1:0] ld_ptr,
  input  logic [DATA_W-1:0] ld_latch,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_rd,
  output logic              mem_wr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata,
  input  logic              mem_rvalid,
  output logic [ADDR_W-1:0] ptr,
  output logic [DATA_W-1:0] latch,
  output logic              busy,
  output logic              done
);

  ptr_op_e ptr_op;
  logic    latch_en, latch_sel_mem;

  tpx_ctrl ctrl_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .cmd_valid     (cmd_valid),
    .cmd_write     (cmd_write),
    .cmd_mode      (amode_e'(cmd_mode)),
    .ld_en         (ld_en),
    .mem_rvalid    (mem_rvalid),
    .cmd_ready     (cmd_ready),
    .busy          (busy),
    .done          (done),
    .mem_rd        (mem_rd),
    .mem_wr        (mem_wr),
    .ptr_op        (ptr_op),
    .latch_en      (latch_en),
    .latch_sel_mem (latch_sel_mem)
  );

  tpx_ptr_reg #(.ADDR_W(ADDR_W)) ptr_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .op       (ptr_op),
    .load_val (ld_ptr),
    .ptr_q    (ptr)
  );

  tpx_latch_reg #(.DATA_W(DATA_W)) latch_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (latch_en),
    .sel_mem (latch_sel_mem),
    .ext_val (ld_latch),
    .mem_val (mem_rdata),
    .q       (latch)
  );

  assign mem_addr  = ptr;
  assign mem_wdata = latch;

endmodule

// File: rtl/tpx_checker.sv
module tpx_checker #(
  parameter int ADDR_W = 21,
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cmd_valid,
  input logic              cmd_ready,
  input logic              ld_en,
  input logic [ADDR_W-1:0] ld_ptr,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              mem_rd,
  input logic              mem_wr,
  input logic [DATA_W-1:0] mem_rdata,
  input logic              mem_rvalid,
  input logic [ADDR_W-1:0] ptr,
  input logic [DATA_W-1:0] latch,
  input logic              busy,
  input logic              done
);

  logic in_rst_q;
  always_ff @(posedge clk) in_rst_q <= !rst_n;

  // R1: first edge after reset release sees cleared state
  always @(posedge clk)
    if (rst_n && in_rst_q === 1'b1)
      a_r1_reset_state: assert (ptr == '0 && latch == '0 && !busy && !done && !mem_rd && !mem_wr);

  a_r2_accept_busy: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_ready |=> busy);

  a_r3_rd_hold: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd && !mem_rvalid |=> mem_rd && $stable(mem_addr) && $stable(latch));

  a_r3_capture: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd && mem_rvalid |=> latch == $past(mem_rdata) && !busy);

  a_r4_wr_single: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr |=> !mem_wr && !busy);

  a_r10_load_idle: assert property (@(posedge clk) disable iff (!rst_n)
    ld_en && !busy |=> ptr == $past(ld_ptr) && !busy);

  a_r11_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy && $past(busy));

  a_r12_no_dual: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd && mem_wr));

  a_r12_strobe_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd || mem_wr) |-> busy);

endmodule

bind tbl_ptr_xfer tpx_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) chk_i (.*);

// File: tb/tbl_ptr_xfer_tb.sv
`timescale 1ns/1ps
module tbl_ptr_xfer_tb_top;
  localparam int AW = 21;
  localparam int DW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cmd_valid = 1'b0, cmd_write = 1'b0, ld_en = 1'b0, mem_rvalid = 1'b0;
  logic [1:0]    cmd_mode = 2'd0;
  logic [AW-1:0] ld_ptr = '0;
  logic [DW-1:0] ld_latch = '0, mem_rdata = '0;
  logic          cmd_ready, mem_rd, mem_wr, busy, done;
  logic [AW-1:0] mem_addr, ptr;
  logic [DW-1:0] mem_wdata, latch;

  always #4 clk = ~clk;

  tbl_ptr_xfer dut_i (.*);

  int checks = 0, fails = 0;
  int rd_lat = 0, lat_cnt = 0;
  logic noise = 1'b0;
  logic [7:0] mem [int];

  function automatic logic [7:0] mem_val(logic [AW-1:0] a);
    if (mem.exists(int'(a))) return mem[int'(a)];
    return a[7:0] ^ a[15:8] ^ 8'h3C;
  endfunction

  // Reference model: updated on each rising edge from the same inputs.
  int            m_st = 0;
  logic [AW-1:0] m_ptr = '0;
  logic [DW-1:0] m_lat = '0;
  logic          m_done = 1'b0;
  logic [1:0]    m_mode = 2'd0;

  task automatic m_post();
    if (m_mode == 2'd1) m_ptr = m_ptr + 1'b1;
    else if (m_mode == 2'd2) m_ptr = m_ptr - 1'b1;
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_st = 0; m_ptr = '0; m_lat = '0; m_done = 1'b0; m_mode = 2'd0;
    end else begin
      m_done = 1'b0;
      case (m_st)
        0: if (ld_en) begin
             m_ptr = ld_ptr; m_lat = ld_latch;
           end else if (cmd_valid) begin
             m_mode = cmd_mode;
             if (cmd_mode == 2'd3) m_ptr = m_ptr + 1'b1;
             m_st = cmd_write ? 2 : 1;
           end
        1: if (mem_rvalid) begin
             m_lat = mem_rdata; m_post(); m_st = 0; m_done = 1'b1;
           end
        default: begin m_post(); m_st = 0; m_done = 1'b1; end
      endcase
    end
  end

  task automatic chk(string tag, string nm, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", tag, nm, act, exp, $time);
    end
  endtask

  task automatic cmp_all();
    chk("R2", "cmd_ready", 32'(cmd_ready), 32'(m_st == 0 && !ld_en));
    chk("R2", "busy", 32'(busy), 32'(m_st != 0));
    chk("R11", "done", 32'(done), 32'(m_done));
    chk("R12", "mem_rd", 32'(mem_rd), 32'(m_st == 1));
    chk("R12", "mem_wr", 32'(mem_wr), 32'(m_st == 2));
    chk("R9", "ptr", 32'(ptr), 32'(m_ptr));
    chk("R3", "latch", 32'(latch), 32'(m_lat));
    if (m_st != 0) chk("R3", "mem_addr", 32'(mem_addr), 32'(m_ptr));
    if (m_st == 2) chk("R4", "mem_wdata", 32'(mem_wdata), 32'(m_lat));
  endtask

  // One cycle: compare at the falling edge, then play the memory's part.
  task automatic tick();
    @(negedge clk);
    if (rst_n) cmp_all();
    if (mem_wr) mem[int'(mem_addr)] = mem_wdata;
    if (mem_rd) begin
      if (lat_cnt >= rd_lat) begin
        mem_rvalid = 1'b1; mem_rdata = mem_val(mem_addr);
      end else begin
        lat_cnt++; mem_rvalid = 1'b0; mem_rdata = 8'($urandom);
      end
    end else begin
      lat_cnt = 0; mem_rvalid = noise; mem_rdata = 8'($urandom);
    end
  endtask

  task automatic load(logic [AW-1:0] p, logic [DW-1:0] l);
    ld_en = 1'b1; ld_ptr = p; ld_latch = l;
    tick();
    ld_en = 1'b0;
    chk("R10", "ptr after load", 32'(ptr), 32'(p));
    chk("R10", "latch after load", 32'(latch), 32'(l));
  endtask

  task automatic xfer(logic w, logic [1:0] md, logic [AW-1:0] exp_ptr, string tag);
    cmd_valid = 1'b1; cmd_write = w; cmd_mode = md;
    tick();
    cmd_valid = 1'b0;
    for (int i = 0; i < 20; i++) begin
      tick();
      if (done) break;
    end
    chk(tag, "done seen", 32'(done), 32'd1);
    chk(tag, "ptr after transfer", 32'(ptr), 32'(exp_ptr));
  endtask

  initial begin
    #(8 * 150000);
    fails++;
    $display("FAIL watchdog expired");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) tick();
    rst_n = 1'b1;
    tick();
    chk("R1", "ptr reset", 32'(ptr), 32'd0);
    chk("R1", "latch reset", 32'(latch), 32'd0);
    chk("R1", "busy reset", 32'(busy), 32'd0);

    rd_lat = 2; noise = 1'b1;
    load(21'h000100, 8'hA5);
    xfer(1'b1, 2'd0, 21'h000100, "R5");                 // plain write
    chk("R4", "memory byte written", 32'(mem_val(21'h100)), 32'hA5);
    xfer(1'b0, 2'd1, 21'h000101, "R6");                 // post-inc read
    chk("R3", "latch read", 32'(latch), 32'hA5);
    xfer(1'b0, 2'd2, 21'h000100, "R7");                 // post-dec read of 0x101
    chk("R7", "latch read", 32'(latch), 32'h3C);
    load(21'h1FFFFF, 8'h77);
    xfer(1'b1, 2'd3, 21'h000000, "R8");                 // pre-inc write wraps to 0
    chk("R9", "wrapped write target", 32'(mem_val(21'h0)), 32'h77);
    rd_lat = 0;
    xfer(1'b0, 2'd2, 21'h1FFFFF, "R9");                 // post-dec wraps down
    chk("R8", "latch from address 0", 32'(latch), 32'h77);

    // load while busy has no effect
    rd_lat = 3;
    cmd_valid = 1'b1; cmd_write = 1'b0; cmd_mode = 2'd0;
    tick();
    cmd_valid = 1'b0; ld_en = 1'b1; ld_ptr = 21'h0ABCDE; ld_latch = 8'h11;
    for (int i = 0; i < 20; i++) begin
      tick();
      if (done) break;
    end
    ld_en = 1'b0;
    chk("R10", "ptr unchanged by busy load", 32'(ptr), 32'h1FFFFF);
    chk("R10", "latch not from busy load", 32'(latch), 32'(mem_val(21'h1FFFFF)));

    for (int i = 0; i < 4000; i++) begin
      cmd_valid = ($urandom % 3) == 0;
      cmd_write = 1'($urandom);
      cmd_mode  = 2'($urandom);
      ld_en     = ($urandom % 12) == 0;
      ld_ptr    = (($urandom % 4) == 0) ? 21'h1FFFFF - 21'($urandom % 3) : 21'($urandom % 64);
      ld_latch  = 8'($urandom);
      rd_lat    = $urandom % 4;
      noise     = 1'($urandom);
      tick();
    end
    cmd_valid = 1'b0; ld_en = 1'b0;
    repeat (8) tick();

    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule